// File: doc/BRIEF.md
# Board Control Register Block

This block is a slave register file on a simple 32-bit bus with one write strobe and a combinational read port. It holds the small set of control registers a development board exposes to software: an eight-LED bar, an eight-character ASCII display buffer, a break/reset byte, a general-purpose output byte, and the drive, enable and select bits of a bit-banged two-wire serial interface. It also accepts a software reset request, which is honoured only when a specific magic value is written.

The display can be filled one character at a time, or all eight characters at once from a single 32-bit word. In the second case the word is rendered as uppercase, zero-padded hexadecimal text, with the most significant nibble shown in the first character. Every register drives its own output port, so board logic sees new values one clock after the bus write that sets them. Writes to addresses outside the map are dropped.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset the outputs hold these values. ledOut is 0x00, brkByte is 0x0A and gpOut is 0x00. twOe is 0, twClkOut and twDatOut are both 1, and twSel is 1. resetReq is 0, and all eight display characters are ASCII space (0x20).
- R2: A write to offset 0x408 loads wrData[7:0] into ledOut, and the new value is visible after the next rising clock edge.
- R3: A write to offset 0x410 sets all eight display characters to the hexadecimal text of wrData. Character i (dispChars[8i+7:8i]) takes nibble wrData[31-4i:28-4i]. Nibble values 0 to 9 map to 0x30 to 0x39, and values 10 to 15 map to 0x41 to 0x46.
- R4: A write to offset 0x418 + 8*i, with i from 0 to 7, loads wrData[7:0] into display character i.
- R5: A write of exactly 32'h0000_0042 to offset 0x500 raises resetReq for exactly one cycle, starting in the cycle after the write. Any other data written to that offset leaves resetReq low.
- R6: Writes store the following fields. Offset 0x508 stores wrData[7:0] into brkByte. Offset 0xA00 stores wrData[7:0] into gpOut. Offset 0xB08 stores wrData[1:0] into twOe. Offset 0xB18 stores wrData[0] into twSel.
- R7: A write to offset 0xB10 stores wrData[1:0]. Bit 1 drives twClkOut and bit 0 drives twDatOut.
- R8: A write to an offset outside the map changes no output. This includes offsets inside the character window that are not multiples of 8, such as 0x41C.
- R9: rdData returns, zero-extended, the stored value of the register at addr. The readable offsets are 0x408, the character offsets, 0x508, 0xA00, 0xB08, 0xB10 and 0xB18. Every other offset, including 0x410 and 0x500, reads as zero.
- R10: When two writes in consecutive cycles target the same display character, the later write determines the final value. This also holds when a whole-word write is followed by a single-character write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for addr/wrData |
| addr | input | ADDR_W | Byte offset for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| ledOut | output | 8 | LED bar |
| dispChars | output | 64 | Display characters, character i in bits 8i+7:8i |
| brkByte | output | 8 | Break/reset byte |
| gpOut | output | 8 | General-purpose output byte |
| resetReq | output | 1 | One-cycle software reset request |
| twClkOut | output | 1 | Two-wire clock line drive |
| twDatOut | output | 1 | Two-wire data line drive |
| twOe | output | 2 | Two-wire output enables |
| twSel | output | 1 | Two-wire bus select |

## Verification
The hardest case to reach from the ports is a whole-word hex write immediately followed by a single-character write to a character that the word write also set. The two writes must fall on back-to-back clock edges, so the bench drives them on consecutive negative edges without an idle cycle in between. Then it checks both the overwritten character and a neighbour that keeps its hex value. The magic-value guard is tested with near misses: one value that is off by one, and one that matches in the low byte but has an extra upper bit set.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_CHARS  = DATA_W / 4;
  localparam int CHAR_IDX_W = $clog2(NUM_CHARS);

  localparam int OFF_LED    = 'h408;
  localparam int OFF_HEX    = 'h410;
  localparam int OFF_CHAR0  = 'h418;
  localparam int CHAR_STEP  = 8;
  localparam int OFF_CHARN  = OFF_CHAR0 + CHAR_STEP * (NUM_CHARS - 1);
  localparam int OFF_RST    = 'h500;
  localparam int OFF_BRK    = 'h508;
  localparam int OFF_GP     = 'hA00;
  localparam int OFF_OE     = 'hB08;
  localparam int OFF_SER    = 'hB10;
  localparam int OFF_SEL    = 'hB18;
  localparam logic [DATA_W-1:0] RST_MAGIC = 32'h0000_0042;

  typedef struct packed {
    logic                  ledWr;
    logic                  hexWr;
    logic                  charWr;
    logic [CHAR_IDX_W-1:0] charIdx;
    logic                  rstFire;
    logic                  brkWr;
    logic                  gpWr;
    logic                  oeWr;
    logic                  serWr;
    logic                  selWr;
  } wrStrobeT;

  typedef enum logic [2:0] {
    RD_NONE, RD_LED, RD_CHAR, RD_BRK, RD_GP, RD_OE, RD_SER, RD_SEL
  } rdSelT;

  function automatic logic [7:0] hexAscii(input logic [3:0] nib);
    if (nib < 4'd10) hexAscii = 8'h30 + {4'h0, nib};
    else             hexAscii = 8'h37 + {4'h0, nib};
  endfunction
endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output wrStrobeT          strobe,
  output rdSelT             rdSel
);
  logic [ADDR_W-1:0] charRel;
  logic              charHit;

  assign charRel = addr - ADDR_W'(OFF_CHAR0);
  assign charHit = (addr >= ADDR_W'(OFF_CHAR0)) && (addr <= ADDR_W'(OFF_CHARN))
                   && (charRel[2:0] == 3'd0);

  always_comb begin
    strobe         = '0;
    strobe.charIdx = charRel[3 +: CHAR_IDX_W];
    strobe.charWr  = wrEn && charHit;
    strobe.ledWr   = wrEn && (addr == ADDR_W'(OFF_LED));
    strobe.hexWr   = wrEn && (addr == ADDR_W'(OFF_HEX));
    strobe.rstFire = wrEn && (addr == ADDR_W'(OFF_RST)) && (wrData == RST_MAGIC);
    strobe.brkWr   = wrEn && (addr == ADDR_W'(OFF_BRK));
    strobe.gpWr    = wrEn && (addr == ADDR_W'(OFF_GP));
    strobe.oeWr    = wrEn && (addr == ADDR_W'(OFF_OE));
    strobe.serWr   = wrEn && (addr == ADDR_W'(OFF_SER));
    strobe.selWr   = wrEn && (addr == ADDR_W'(OFF_SEL));
  end

  always_comb begin
    if (charHit)                          rdSel = RD_CHAR;
    else if (addr == ADDR_W'(OFF_LED))    rdSel = RD_LED;
    else if (addr == ADDR_W'(OFF_BRK))    rdSel = RD_BRK;
    else if (addr == ADDR_W'(OFF_GP))     rdSel = RD_GP;
    else if (addr == ADDR_W'(OFF_OE))     rdSel = RD_OE;
    else if (addr == ADDR_W'(OFF_SER))    rdSel = RD_SER;
    else if (addr == ADDR_W'(OFF_SEL))    rdSel = RD_SEL;
    else                                  rdSel = RD_NONE;
  end
endmodule

// File: rtl/board_ctl_datapath.sv
module board_ctl_datapath
  import board_ctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  wrStrobeT               strobe,
  input  rdSelT                  rdSel,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic [7:0]             ledOut,
  output logic [8*NUM_CHARS-1:0] dispChars,
  output logic [7:0]             brkByte,
  output logic [7:0]             gpOut,
  output logic                   resetReq,
  output logic [1:0]             serReg,
  output logic [1:0]             twOe,
  output logic                   twSel
);
  logic [7:0] charMem [NUM_CHARS];

  for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
    localparam int NIB_LSB = DATA_W - 4 * (i + 1);
    always_ff @(posedge clk) begin
      if (!rstN)
        charMem[i] <= 8'h20;
      else if (strobe.hexWr)
        charMem[i] <= hexAscii(wrData[NIB_LSB +: 4]);
      else if (strobe.charWr && (strobe.charIdx == CHAR_IDX_W'(i)))
        charMem[i] <= wrData[7:0];
    end
    assign dispChars[8*i +: 8] = charMem[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledOut   <= 8'h00;
      brkByte  <= 8'h0A;
      gpOut    <= 8'h00;
      resetReq <= 1'b0;
      serReg   <= 2'b11;
      twOe     <= 2'b00;
      twSel    <= 1'b1;
    end else begin
      resetReq <= strobe.rstFire;
      if (strobe.ledWr) ledOut  <= wrData[7:0];
      if (strobe.brkWr) brkByte <= wrData[7:0];
      if (strobe.gpWr)  gpOut   <= wrData[7:0];
      if (strobe.serWr) serReg  <= wrData[1:0];
      if (strobe.oeWr)  twOe    <= wrData[1:0];
      if (strobe.selWr) twSel   <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_LED:  rdData[7:0] = ledOut;
      RD_CHAR: rdData[7:0] = charMem[strobe.charIdx];
      RD_BRK:  rdData[7:0] = brkByte;
      RD_GP:   rdData[7:0] = gpOut;
      RD_OE:   rdData[1:0] = twOe;
      RD_SER:  rdData[1:0] = serReg;
      RD_SEL:  rdData[0]   = twSel;
      default: rdData      = '0;
    endcase
  end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [7:0]        ledOut,
  output logic [63:0]       dispChars,
  output logic [7:0]        brkByte,
  output logic [7:0]        gpOut,
  output logic              resetReq,
  output logic              twClkOut,
  output logic              twDatOut,
  output logic [1:0]        twOe,
  output logic              twSel
);
  wrStrobeT   strobe;
  rdSelT      rdSel;
  logic [1:0] serReg;

  board_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  board_ctl_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wrData    (wrData),
    .rdData    (rdData),
    .ledOut    (ledOut),
    .dispChars (dispChars),
    .brkByte   (brkByte),
    .gpOut     (gpOut),
    .resetReq  (resetReq),
    .serReg    (serReg),
    .twOe      (twOe),
    .twSel     (twSel)
  );

  assign twClkOut = serReg[1];
  assign twDatOut = serReg[0];
endmodule

// File: rtl/board_ctl_checker.sv
module board_ctl_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [7:0]        ledOut,
  input logic [63:0]       dispChars,
  input logic              resetReq,
  input logic              twClkOut,
  input logic              twDatOut
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R5

  AST_RST_MAGIC_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(wrEn) && $past(addr) == ADDR_W'('h500)
                  && $past(wrData) == 32'h42)); // R5

  AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'('h408)) |=> ledOut == $past(wrData[7:0])); // R2

  AST_SER_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'('hB10)) |=>
      (twClkOut == $past(wrData[1]) && twDatOut == $past(wrData[0]))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(ledOut) && $stable(dispChars))); // R8
endmodule

bind board_ctl_regs board_ctl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .ledOut    (ledOut),
  .dispChars (dispChars),
  .resetReq  (resetReq),
  .twClkOut  (twClkOut),
  .twDatOut  (twDatOut)
);

// File: tb/board_ctl_regs_bench.sv
`timescale 1ns/1ps
module board_ctl_regs_bench;
  localparam int AW = 20;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [AW-1:0] addr;
  logic [31:0]   wrData;
  logic [31:0]   rdData;
  logic [7:0]    ledOut, brkByte, gpOut;
  logic [63:0]   dispChars;
  logic          resetReq, twClkOut, twDatOut, twSel;
  logic [1:0]    twOe;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  board_ctl_regs #(.ADDR_W(AW)) u_board_ctl_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ledOut(ledOut), .dispChars(dispChars), .brkByte(brkByte),
    .gpOut(gpOut), .resetReq(resetReq), .twClkOut(twClkOut), .twDatOut(twDatOut),
    .twOe(twOe), .twSel(twSel)
  );

  // {write addr, write data, read addr, expected rdData}
  localparam logic [103:0] VEC [NV] = '{
    {20'h408, 32'h1234_56A5, 20'h408, 32'h0000_00A5}, // R2 low byte only
    {20'h410, 32'hDEAD_BEEF, 20'h418, 32'h0000_0044}, // R3 char0 'D'
    {20'hFFC, 32'h0000_0000, 20'h430, 32'h0000_0044}, // R3 char3 'D'
    {20'h000, 32'h0000_0000, 20'h438, 32'h0000_0042}, // R3 char4 'B'
    {20'h410, 32'h0009_A0F1, 20'h418, 32'h0000_0030}, // R3 zero pad '0'
    {20'h000, 32'h0000_0000, 20'h430, 32'h0000_0039}, // R3 '9'
    {20'h000, 32'h0000_0000, 20'h438, 32'h0000_0041}, // R3 'A'
    {20'h000, 32'h0000_0000, 20'h450, 32'h0000_0031}, // R3 last char '1'
    {20'h440, 32'h0000_017A, 20'h440, 32'h0000_007A}, // R4 char5
    {20'h508, 32'h0000_01FF, 20'h508, 32'h0000_00FF}, // R6 break byte
    {20'hA00, 32'h0000_003C, 20'hA00, 32'h0000_003C}, // R6 gp out
    {20'hB08, 32'h0000_00FF, 20'hB08, 32'h0000_0003}, // R6 enables 2 bits
    {20'hB18, 32'h0000_0002, 20'hB18, 32'h0000_0000}, // R6 select 1 bit
    {20'hB10, 32'h0000_0001, 20'hB10, 32'h0000_0001}, // R7 serial value
    {20'h41C, 32'h0000_0055, 20'h418, 32'h0000_0030}, // R8 misaligned char
    {20'h404, 32'h0000_0077, 20'h404, 32'h0000_0000}, // R9 unmapped read
    {20'h500, 32'h0000_0042, 20'h500, 32'h0000_0000}, // R9 reset reg reads 0
    {20'h000, 32'h0000_0000, 20'h410, 32'h0000_0000}  // R9 word reg reads 0
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
  endtask

  task automatic idle;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
    #1;
  endtask

  task automatic readAt(input logic [AW-1:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] snapDisp;
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ledOut", ledOut, 8'h00);
    chk("R1 brkByte", brkByte, 8'h0A);
    chk("R1 gpOut", gpOut, 8'h00);
    chk("R1 twOe", twOe, 2'b00);
    chk("R1 serial pins", {twClkOut, twDatOut}, 2'b11);
    chk("R1 twSel", twSel, 1'b1);
    chk("R1 resetReq", resetReq, 1'b0);
    chk("R1 dispChars", dispChars, {8{8'h20}});

    // Vector table
    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][103:84], VEC[i][83:52]);
      idle();
      readAt(VEC[i][51:32]);
      chk($sformatf("vector %0d rdData", i), rdData, VEC[i][31:0]);
    end
    chk("R2 ledOut port", ledOut, 8'hA5);

    // R5 magic value: pulse one cycle, starting the cycle after the write
    doWrite(20'h500, 32'h42);
    idle();
    chk("R5 pulse high", resetReq, 1'b1);
    idle();
    chk("R5 pulse one cycle", resetReq, 1'b0);
    doWrite(20'h500, 32'h43);
    idle();
    chk("R5 near miss 0x43", resetReq, 1'b0);
    doWrite(20'h500, 32'h142);
    idle();
    chk("R5 upper bit set", resetReq, 1'b0);

    // R7 pin mapping
    doWrite(20'hB10, 32'h2);
    idle();
    chk("R7 clk line", twClkOut, 1'b1);
    chk("R7 dat line", twDatOut, 1'b0);

    // R8 unmapped write changes no output
    snapDisp = dispChars;
    doWrite(20'hB00, 32'hFFFF_FFFF);
    idle();
    chk("R8 display kept", dispChars, snapDisp);
    chk("R8 other outputs kept",
        {ledOut, brkByte, gpOut, twOe, twSel, twClkOut, twDatOut},
        {8'hA5, 8'hFF, 8'h3C, 2'b11, 1'b0, 1'b1, 1'b0});

    // R10 back-to-back writes to the same character
    doWrite(20'h420, 32'h78);
    doWrite(20'h420, 32'h79);
    idle();
    chk("R10 char1 later wins", dispChars[15:8], 8'h79);
    doWrite(20'h410, 32'hCAFE_0123);
    doWrite(20'h418, 32'h5A);
    idle();
    chk("R10 char0 after hex", dispChars[7:0], 8'h5A);
    chk("R3 char1 from hex", dispChars[15:8], 8'h41);
    chk("R3 last char from hex", dispChars[63:56], 8'h33);

    // R4 port-level single char
    doWrite(20'h450, 32'h21);
    idle();
    chk("R4 char7 port", dispChars[63:56], 8'h21);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule